// File: doc/BRIEF.md
# Dual-Channel Compare Match Timer

This block provides two independent 16-bit periodic timers behind a small 16-bit register bus. Each channel has an up-counter, a compare register and a control register. The counter advances from the system clock through a per-channel prescaler with one of four ratios. When the counter reaches its compare value, it returns to zero. If that channel's interrupt is enabled, the channel then drives a single-cycle pulse on its interrupt line. A shared run register starts and stops the two channels separately.

Software loads the period into the compare register and picks the divisor and interrupt enable in the control register. It then sets the channel's run bit. The interrupt rate is the system clock divided by the prescale ratio and by the number of counts per period. The counter can be read or overwritten at any time.

Top module: `cmt_dual`

## Requirements
- R1: After reset, the run register and both control registers read 0, both counters read 0 and both compare registers read 0xFFFF.
- R2: Registers are 16-bit words selected by bus_addr[3:1], and bus_addr[0] is ignored. Byte offset 0 is the run register. Offsets 2, 4 and 6 are channel 0 control, counter and compare. Offsets 8, 10 and 12 are the same three registers for channel 1. Offset 14 reads 0, and a write to it changes nothing.
- R3: Run register bit 0 enables counting on channel 0 and bit 1 enables channel 1. All other bits are not stored and read as 0.
- R4: In each control register, bits [1:0] select the prescale ratio: 0 gives 8, 1 gives 32, 2 gives 128 and 3 gives 512. Bit 6 enables the interrupt. All other bits read as 0.
- R5: A running channel increments its counter once every N clock cycles, where N is the selected ratio. The first increment comes N cycles after the run bit is written to 1. Stopping a channel clears its prescaler, so a restart again waits a full N cycles.
- R6: While its run bit is 0, a channel's counter holds its value unless software writes it.
- R7: On an increment, if the incremented value is greater than or equal to the compare value, the counter becomes 0 instead. A compare value of 0 therefore clears on every prescaled tick.
- R8: When R7 clears the counter and the control interrupt bit was set before that clock edge, irq[ch] is high for exactly one cycle, the cycle right after that edge. Otherwise irq[ch] stays low.
- R9: A bus write to a counter takes priority over an increment at the same clock edge. The written value is stored, and that tick neither increments nor matches.
- R10: Each channel's counting, matching and interrupt depend only on its own registers and its own run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one 16-bit word per cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel compare-match interrupt pulse |

## Verification
A wrong prescaler phase or limit shows first as an irq pulse that comes one or more cycles early or late. The bench compares irq against its own model on every cycle, so such an error is caught at the first match, at most one compare period after the channel starts. A counter that drifts, or that ignores write priority, shows on the next read of the counter word. Reads are made right after restarts, at exact tick edges and while the channel is stopped, so the faulty cycle is found within one prescale period of where it happens.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    // control register layout: the divisor select sits in the low bits
    localparam int CMT_CKS_W   = 2;
    localparam int CMT_IE_BIT  = 6;
    // prescale ratio = 2^(BASE + STEP*select)
    localparam int CMT_PRE_BASE_LOG2 = 3;
    localparam int CMT_PRE_STEP_LOG2 = 2;
    // registers per channel and their order after the run word
    localparam int CMT_WORDS_PER_CH = 3;
    typedef enum int {
        FLD_CTL = 0,
        FLD_CNT = 1,
        FLD_CMP = 2
    } cmt_field_e;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int CKS_W     = cmt_pkg::CMT_CKS_W,
    parameter int BASE_LOG2 = cmt_pkg::CMT_PRE_BASE_LOG2,
    parameter int STEP_LOG2 = cmt_pkg::CMT_PRE_STEP_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * ((1 << CKS_W) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = PRE_W'((32'd1 << (BASE_LOG2 + STEP_LOG2 * int'(cks))) - 32'd1);
        // >= so that a smaller ratio chosen mid-period still ticks at once
        tick = run && (s_q.pre >= lim);
        s_d  = s_q;
        if (!run || tick) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int CKS_W  = cmt_pkg::CMT_CKS_W,
    parameter int IE_BIT = cmt_pkg::CMT_IE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_ctl,
    input  logic              wr_cnt,
    input  logic              wr_cmp,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cmp,
    output logic              irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CKS_W-1:0] cks;
        logic             ie;
        logic             irq;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic             tick;
    logic [CNT_W:0]   inc;
    logic             hit;

    cmt_prescaler #(.CKS_W(CKS_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .cks  (s_q.cks),
        .tick (tick)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        inc     = {1'b0, s_q.cnt} + 1'b1;
        hit     = tick && (inc >= {1'b0, s_q.cmp});
        if (wr_cnt) begin
            s_d.cnt = wdata[CNT_W-1:0];
        end else if (hit) begin
            s_d.cnt = '0;
            s_d.irq = s_q.ie;
        end else if (tick) begin
            s_d.cnt = inc[CNT_W-1:0];
        end
        if (wr_cmp) begin
            s_d.cmp = wdata[CNT_W-1:0];
        end
        if (wr_ctl) begin
            s_d.cks = wdata[CKS_W-1:0];
            s_d.ie  = wdata[IE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.cmp <= '1;
            s_q.cks <= '0;
            s_q.ie  <= 1'b0;
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl_rd              = '0;
        ctl_rd[CKS_W-1:0]   = s_q.cks;
        ctl_rd[IE_BIT]      = s_q.ie;
    end

    assign cnt = s_q.cnt;
    assign cmp = s_q.cmp;
    assign irq = s_q.irq;
endmodule

// File: rtl/cmt_dual.sv
module cmt_dual #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int CKS_W  = cmt_pkg::CMT_CKS_W,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    import cmt_pkg::*;

    localparam int WORD_W = ADDR_W - 1;

    typedef struct packed {
        logic [NUM_CH-1:0] run;
    } top_state_t;

    top_state_t s_d, s_q;
    logic [WORD_W-1:0] word;

    logic [NUM_CH-1:0]             wr_ctl, wr_cnt, wr_cmp;
    logic [NUM_CH-1:0][DATA_W-1:0] ctl_rd;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_v, cmp_v;

    assign word = bus_addr[ADDR_W-1:1];

    always_comb begin
        s_d = s_q;
        if (bus_wr && (word == '0)) begin
            s_d.run = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BASE = 1 + CMT_WORDS_PER_CH * i;
        assign wr_ctl[i] = bus_wr && (word == WORD_W'(BASE + FLD_CTL));
        assign wr_cnt[i] = bus_wr && (word == WORD_W'(BASE + FLD_CNT));
        assign wr_cmp[i] = bus_wr && (word == WORD_W'(BASE + FLD_CMP));

        cmt_channel #(
            .CNT_W (CNT_W),
            .DATA_W(DATA_W),
            .CKS_W (CKS_W)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (s_q.run[i]),
            .wr_ctl(wr_ctl[i]),
            .wr_cnt(wr_cnt[i]),
            .wr_cmp(wr_cmp[i]),
            .wdata (bus_wdata),
            .ctl_rd(ctl_rd[i]),
            .cnt   (cnt_v[i]),
            .cmp   (cmp_v[i]),
            .irq   (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (word == '0) begin
            bus_rdata = DATA_W'(s_q.run);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (word == WORD_W'(1 + CMT_WORDS_PER_CH * i + FLD_CTL)) bus_rdata = ctl_rd[i];
            if (word == WORD_W'(1 + CMT_WORDS_PER_CH * i + FLD_CNT)) bus_rdata = DATA_W'(cnt_v[i]);
            if (word == WORD_W'(1 + CMT_WORDS_PER_CH * i + FLD_CMP)) bus_rdata = DATA_W'(cmp_v[i]);
        end
    end
endmodule

// File: rtl/cmt_dual_chk.sv
module cmt_dual_chk #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int IE_BIT = cmt_pkg::CMT_IE_BIT
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CH-1:0]           run,
    input logic [NUM_CH-1:0]           wr_cnt,
    input logic [NUM_CH-1:0][DATA_W-1:0] ctl,
    input logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0]           irq
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R8
        irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |=> !irq[i]);
        // R8
        irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(ctl[i][IE_BIT]));
        // R7
        irq_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (cnt[i] == '0));
        // R6
        stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !wr_cnt[i]) |=> $stable(cnt[i]));
        // R5
        step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && !wr_cnt[i]) |=> ($stable(cnt[i]) || (cnt[i] == '0) ||
                                        (cnt[i] == $past(cnt[i]) + 1'b1)));
    end
endmodule

bind cmt_dual cmt_dual_chk #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (s_q.run),
    .wr_cnt(wr_cnt),
    .ctl   (ctl_rd),
    .cnt   (cnt_v),
    .irq   (irq)
);

// File: tb/sim_cmt_dual.sv
`timescale 1ns/1ps
module sim_cmt_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmt_dual u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference
    int m_start;
    int m_cks[2], m_ie[2], m_cnt[2], m_cmp[2], m_pre[2];
    bit m_irq[2];
    int mw, mdiv, mn;
    bit mtk, mrun;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0;
            for (int c = 0; c < 2; c++) begin
                m_cks[c] = 0; m_ie[c] = 0; m_cnt[c] = 0; m_cmp[c] = 'hFFFF;
                m_pre[c] = 0; m_irq[c] = 0;
            end
        end else begin
            mw = bus_wr ? int'(bus_addr >> 1) : -1;
            for (int c = 0; c < 2; c++) begin
                mdiv = 8 << (2 * m_cks[c]);
                mrun = ((m_start >> c) & 1) != 0;
                mtk  = mrun && (m_pre[c] >= mdiv - 1);
                m_pre[c] = (!mrun || mtk) ? 0 : m_pre[c] + 1;
                m_irq[c] = 0;
                if (mw == 2 + 3 * c) begin
                    m_cnt[c] = int'(bus_wdata);
                end else if (mtk) begin
                    mn = m_cnt[c] + 1;
                    if (mn >= m_cmp[c]) begin
                        m_cnt[c] = 0;
                        m_irq[c] = (m_ie[c] != 0);
                    end else begin
                        m_cnt[c] = mn;
                    end
                end
                if (mw == 1 + 3 * c) begin
                    m_cks[c] = int'(bus_wdata[1:0]);
                    m_ie[c]  = int'(bus_wdata[6]);
                end
                if (mw == 3 + 3 * c) m_cmp[c] = int'(bus_wdata);
            end
            if (mw == 0) m_start = int'(bus_wdata[1:0]);
        end
    end

    function automatic int model_read(input logic [3:0] a);
        int w = int'(a >> 1);
        if (w == 0) return m_start;
        for (int c = 0; c < 2; c++) begin
            if (w == 1 + 3 * c) return m_cks[c] | (m_ie[c] << 6);
            if (w == 2 + 3 * c) return m_cnt[c];
            if (w == 3 + 3 * c) return m_cmp[c];
        end
        return 0;
    endfunction

    // irq compared every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 2; c++) begin
                checks++;
                if (irq[c] !== m_irq[c]) begin
                    errors++;
                    $display("FAIL R8/R7 ch%0d irq at %0t actual=%0b expected=%0b",
                             c, $time, irq[c], m_irq[c]);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== 16'(model_read(a))) begin
            errors++;
            $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, bus_rdata,
                     16'(model_read(a)));
        end
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [15:0] e, input string tag);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 16; a += 2) rd_chk(4'(a), tag);
    endtask

    initial begin
        logic [15:0] cap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values, R2 offset 14 reads zero
        rd_exp(4'd0, 16'h0000, "R1");
        rd_exp(4'd2, 16'h0000, "R1");
        rd_exp(4'd4, 16'h0000, "R1");
        rd_exp(4'd6, 16'hFFFF, "R1");
        rd_exp(4'd8, 16'h0000, "R1");
        rd_exp(4'd10, 16'h0000, "R1");
        rd_exp(4'd12, 16'hFFFF, "R1");
        rd_exp(4'd14, 16'h0000, "R2");

        // R4 only divisor and enable bits stored; R3 only two run bits
        wr(4'd2, 16'hFFFF);
        rd_exp(4'd2, 16'h0043, "R4");
        wr(4'd8, 16'hFFBC);
        rd_exp(4'd8, 16'h0000, "R4");
        wr(4'd0, 16'hFFFC);
        rd_exp(4'd0, 16'h0000, "R3");

        // R2 address bit 0 ignored, offset 14 write has no effect
        wr(4'd7, 16'h1234);
        rd_exp(4'd6, 16'h1234, "R2");
        wr(4'd15, 16'hFFFF);
        rd_exp(4'd14, 16'h0000, "R2");
        read_all("R2");

        // R5 R7 R8 ch0 divide 8, period 3, irq on; ch1 divide 32, no irq (R10)
        wr(4'd2, 16'h0040);
        wr(4'd6, 16'd3);
        wr(4'd8, 16'h0001);
        wr(4'd12, 16'd5);
        wr(4'd0, 16'h0001);
        run_cycles(7);
        rd_exp(4'd4, 16'h0000, "R5");
        run_cycles(1);
        rd_exp(4'd4, 16'h0001, "R5");
        rd_exp(4'd10, 16'h0000, "R10");
        wr(4'd0, 16'h0003);
        for (int k = 0; k < 20; k++) begin
            run_cycles(13);
            read_all("R7");
        end

        // R6 stop ch0, counter holds
        wr(4'd0, 16'h0002);
        cap = bus_rdata;
        rd_chk(4'd4, "R6");
        cap = bus_rdata;
        run_cycles(40);
        rd_exp(4'd4, cap, "R6");

        // R5 restart waits a full period
        wr(4'd0, 16'h0003);
        run_cycles(7);
        rd_exp(4'd4, cap, "R5");
        run_cycles(1);
        rd_exp(4'd4, (cap == 16'd2) ? 16'h0000 : cap + 16'd1, "R5");

        // R7 compare of zero clears each tick
        wr(4'd6, 16'h0000);
        run_cycles(60);
        rd_chk(4'd4, "R7");

        // R9 counter write at a tick edge wins
        wr(4'd6, 16'hFFFF);
        forever begin
            @(negedge clk);
            if (m_pre[0] == 7) break;
        end
        bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 16'h0100;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_exp(4'd4, 16'h0100, "R9");
        run_cycles(8);
        rd_exp(4'd4, 16'h0101, "R9");

        // counter written above compare: next tick clears (R7)
        wr(4'd6, 16'd4);
        wr(4'd4, 16'd9);
        run_cycles(10);
        rd_chk(4'd4, "R7");

        // R4 largest divisor on ch1 with irq
        wr(4'd8, 16'h0043);
        wr(4'd12, 16'd2);
        wr(4'd10, 16'd0);
        run_cycles(1600);
        read_all("R4");

        // R10 ch1 only
        wr(4'd0, 16'h0002);
        run_cycles(600);
        read_all("R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule